// File: doc/BRIEF.md
# Tagged-Byte SPI Master

This block is an SPI master that sits on a simple register bus (write strobe, read strobe, word address, write data, combinational read data) and serves up to four serial peripherals, each with its own active-low select line. Software first writes a tag register with a 2-bit channel number and an end-of-frame flag. It then writes one byte to the transmit register. The block moves that byte into its shifter, sends it MSB first while it captures the byte coming back, and stores the received byte together with the tag it was sent under. Software can then compare the returned tag with the one it issued.

A frame is a run of bytes. The select line of the addressed channel goes low when a byte starts and stays low across untagged bytes. It is released half a bit period after the last clock edge of a byte tagged end-of-frame. Clock polarity, clock phase and a half-period divisor are programmable. To read a peripheral without sending real data, software sends 0xFF as dummy data. A one-word holding register in front of the shifter lets software queue the next byte while the current one is still in flight. Two sticky events, for a byte taken and for a byte received, drive a maskable interrupt.

Top module: `tagged_spi_master`

## Requirements
- R1: After reset, all four selects are high, sclk is 0, irq is 0, STATE (address 6) reads 0x2 (tx_empty only), and EVENTS (address 7) reads 0.
- R2: TXTAG (address 2) holds the channel in bits [1:0] and end-of-frame in bit 2. A write to TXBYTE (address 3) queues the byte under the current tag. While that byte is sent, only cs_n[channel] is low.
- R3: Data moves MSB first in both directions. The 8 bits on mosi equal the written byte, and RXBYTE (address 5) returns the 8 bits sampled on miso.
- R4: CTRL (address 0) has enable in bit 0, phase in bit 1 and polarity in bit 2. sclk idles at the polarity value. With phase 0, data is sampled on the leading edge; with phase 1, on the trailing edge. Each byte makes exactly 16 sclk transitions, and sclk ends at its idle level.
- R5: BAUD (address 1) holds a value N, and one half bit period is N clocks, with N=0 treated as 1. A byte loads on the second clock edge after its TXBYTE write and keeps STATE bit 0 (busy) high for 17·N clocks.
- R6: After a byte without end-of-frame, the select stays low. After a byte with end-of-frame, it goes high one half period after the last sclk edge.
- R7: RXTAG (address 4) returns, in bits [1:0] and bit 2, the channel and end-of-frame flag of the byte currently in RXBYTE.
- R8: STATE has busy in bit 0, tx_empty in bit 1 and rx_full in bit 2. A TXBYTE write clears tx_empty until the shifter takes the byte. rx_full is set when a byte completes and cleared when RXBYTE is read.
- R9: EVENTS bit 0 latches when a byte is taken, and bit 1 latches when a byte is received. Writing 1 to a bit clears it. irq is the OR of the events masked by EVMASK (address 8), so a mask of 0 keeps irq low.
- R10: While enable is 0, a queued byte is not started and the selects stay high. Setting enable starts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on RXBYTE) |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Masked event interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low selects, one per channel |

## Verification
The assertions assume that CTRL and BAUD stay unchanged while a byte is in flight. They also assume that software changes polarity only while every select is high, since a mid-byte change would move sclk off its expected idle level. The bench keeps within these limits: it reprograms the mode only after an end-of-frame byte has completed, and it waits on STATE busy before it queues the next byte. A behavioural slave answers on sclk edges according to the programmed phase, and a per-clock model of the expected select and idle clock levels is compared on every cycle.

// File: rtl/tspi_pkg.sv
package tspi_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CH_N   = 4;
    localparam int unsigned CH_W   = $clog2(CH_N);
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned EDGES  = 2 * BYTE_W;
    localparam int unsigned EDGE_W = $clog2(EDGES + 1);
    localparam int unsigned EV_W   = 2;

    // packs as {eof, chan}: chan in [1:0], eof in bit 2
    typedef struct packed {
        logic            eof;
        logic [CH_W-1:0] chan;
    } tag_t;

    typedef struct packed {
        tag_t              tag;
        logic [BYTE_W-1:0] data;
    } word_t;

    // packs as {cpol, cpha, en}
    typedef struct packed {
        logic cpol;
        logic cpha;
        logic en;
    } mode_t;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 4'd0,
        RA_BAUD   = 4'd1,
        RA_TXTAG  = 4'd2,
        RA_TXBYTE = 4'd3,
        RA_RXTAG  = 4'd4,
        RA_RXBYTE = 4'd5,
        RA_STATE  = 4'd6,
        RA_EVENTS = 4'd7,
        RA_EVMASK = 4'd8
    } reg_addr_e;

    function automatic logic [CH_N-1:0] chan_select(input logic [CH_W-1:0] c);
        logic [CH_N-1:0] v;
        v    = '0;
        v[c] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/tspi_baud.sv
module tspi_baud
    import tspi_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);

    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] cnt_q;

    // a divisor of zero behaves as one
    assign half = (divisor == '0) ? DIV_W'(1) : divisor;
    assign tick = run && (cnt_q == half - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/tspi_engine.sv
module tspi_engine
    import tspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  word_t             load_word,
    input  logic              cpha,
    input  logic              cpol,
    input  logic              tick,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rx_data,
    output tag_t              rx_tag,
    output logic              sclk,
    output logic [CH_N-1:0]   cs_n,
    output logic              mosi
);

    logic              busy_q;
    logic              done_q;
    logic              sclk_q;
    logic [CH_N-1:0]   cs_n_q;
    logic [EDGE_W-1:0] edge_q;
    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] rx_q;
    tag_t              tag_q;
    tag_t              rx_tag_q;

    logic last_slot;
    logic sample_now;
    logic shift_now;

    // edge slots 0..15 toggle sclk, slot 16 closes the byte
    assign last_slot  = (edge_q == EDGE_W'(EDGES));
    assign sample_now = (edge_q[0] == cpha);
    assign shift_now  = (edge_q[0] != cpha) && !(cpha && (edge_q == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            sclk_q   <= 1'b0;
            cs_n_q   <= '1;
            edge_q   <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            rx_q     <= '0;
            tag_q    <= '0;
            rx_tag_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                sclk_q <= cpol;
                if (start) begin
                    busy_q <= 1'b1;
                    edge_q <= '0;
                    tx_sh  <= load_word.data;
                    tag_q  <= load_word.tag;
                    cs_n_q <= ~chan_select(load_word.tag.chan);
                end
            end else if (tick) begin
                if (last_slot) begin
                    busy_q   <= 1'b0;
                    done_q   <= 1'b1;
                    rx_q     <= rx_sh;
                    rx_tag_q <= tag_q;
                    if (tag_q.eof) begin
                        cs_n_q <= '1;
                    end
                end else begin
                    sclk_q <= ~sclk_q;
                    edge_q <= edge_q + 1'b1;
                    if (sample_now) begin
                        rx_sh <= {rx_sh[BYTE_W-2:0], miso};
                    end
                    if (shift_now) begin
                        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign rx_data = rx_q;
    assign rx_tag  = rx_tag_q;
    assign sclk    = sclk_q;
    assign cs_n    = cs_n_q;
    assign mosi    = tx_sh[BYTE_W-1];

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n_q)); // R2
    AST_BUSY_SELECTED: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cs_n_q != '1)); // R6
    AST_SCLK_HOME: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> (sclk_q == cpol)); // R4

endmodule

// File: rtl/tspi_regfile.sv
module tspi_regfile
    import tspi_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [BYTE_W-1:0] rx_data,
    input  tag_t              rx_tag,
    output logic              start,
    output word_t             load_word,
    output mode_t             mode,
    output logic [DIV_W-1:0]  divisor,
    output logic              irq
);

    mode_t            mode_q;
    logic [DIV_W-1:0] div_q;
    tag_t             txtag_q;
    word_t            hold_q;
    logic             hold_full_q;
    logic             rx_full_q;
    logic [EV_W-1:0]  ev_q;
    logic [EV_W-1:0]  mask_q;
    logic [EV_W-1:0]  ev_clr;
    logic             wr_tx;
    logic             rd_rx;
    logic             unused_wdata;

    assign wr_tx        = bus_wr && (bus_addr == RA_TXBYTE);
    assign rd_rx        = bus_rd && (bus_addr == RA_RXBYTE);
    assign ev_clr       = (bus_wr && (bus_addr == RA_EVENTS)) ? bus_wdata[EV_W-1:0] : '0;
    assign start        = hold_full_q && mode_q.en && !busy;
    assign unused_wdata = ^bus_wdata[DATA_W-1:BYTE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= '0;
            div_q       <= DIV_W'(1);
            txtag_q     <= '0;
            hold_q      <= '0;
            hold_full_q <= 1'b0;
            rx_full_q   <= 1'b0;
            ev_q        <= '0;
            mask_q      <= '0;
        end else begin
            if (bus_wr) begin
                case (reg_addr_e'(bus_addr))
                    RA_CTRL:   mode_q  <= mode_t'(bus_wdata[2:0]);
                    RA_BAUD:   div_q   <= bus_wdata[DIV_W-1:0];
                    RA_TXTAG:  txtag_q <= tag_t'(bus_wdata[CH_W:0]);
                    RA_EVMASK: mask_q  <= bus_wdata[EV_W-1:0];
                    default: ;
                endcase
            end
            if (start) begin
                hold_full_q <= 1'b0;
            end
            if (wr_tx) begin
                hold_q      <= '{tag: txtag_q, data: bus_wdata[BYTE_W-1:0]};
                hold_full_q <= 1'b1;
            end
            if (done) begin
                rx_full_q <= 1'b1;
            end else if (rd_rx) begin
                rx_full_q <= 1'b0;
            end
            ev_q <= (ev_q & ~ev_clr) | {done, start};
        end
    end

    always_comb begin
        case (reg_addr_e'(bus_addr))
            RA_CTRL:   bus_rdata = DATA_W'(mode_q);
            RA_BAUD:   bus_rdata = DATA_W'(div_q);
            RA_TXTAG:  bus_rdata = DATA_W'(txtag_q);
            RA_RXTAG:  bus_rdata = DATA_W'(rx_tag);
            RA_RXBYTE: bus_rdata = DATA_W'(rx_data);
            RA_STATE:  bus_rdata = DATA_W'({rx_full_q, !hold_full_q, busy});
            RA_EVENTS: bus_rdata = DATA_W'(ev_q);
            RA_EVMASK: bus_rdata = DATA_W'(mask_q);
            default:   bus_rdata = '0;
        endcase
    end

    assign load_word = hold_q;
    assign mode      = mode_q;
    assign divisor   = div_q;
    assign irq       = |(ev_q & mask_q);

    AST_TX_PENDING: assert property (@(posedge clk) disable iff (rst)
        wr_tx |=> !hold_full_q == 1'b0); // R8
    AST_RX_FROM_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_full_q) |-> $past(done)); // R8

endmodule

// File: rtl/tagged_spi_master.sv
module tagged_spi_master
    import tspi_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic [3:0]  cs_n
);

    logic              start;
    word_t             load_word;
    mode_t             mode;
    logic [DIV_W-1:0]  divisor;
    logic              busy;
    logic              done;
    logic              tick;
    logic [BYTE_W-1:0] rx_data;
    tag_t              rx_tag;

    tspi_regfile #(.DIV_W(DIV_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .done      (done),
        .rx_data   (rx_data),
        .rx_tag    (rx_tag),
        .start     (start),
        .load_word (load_word),
        .mode      (mode),
        .divisor   (divisor),
        .irq       (irq)
    );

    tspi_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .divisor (divisor),
        .tick    (tick)
    );

    tspi_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .load_word (load_word),
        .cpha      (mode.cpha),
        .cpol      (mode.cpol),
        .tick      (tick),
        .miso      (miso),
        .busy      (busy),
        .done      (done),
        .rx_data   (rx_data),
        .rx_tag    (rx_tag),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .mosi      (mosi)
    );

endmodule

// File: tb/test_tagged_spi_master.sv
module test_tagged_spi_master;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        sclk;
    logic        mosi;
    logic        miso;
    logic [3:0]  cs_n;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    // behavioural slave and reference state
    logic [7:0] slv_tx = 8'h00;
    logic [7:0] slv_rx = 8'h00;
    int         slv_lead = 0;
    int         toggles = 0;
    logic       cpol_b = 1'b0;
    logic       cpha_b = 1'b0;
    logic       pending = 1'b1;
    logic       in_byte = 1'b0;
    logic [3:0] cur_cs = 4'hF;
    logic [3:0] held_cs = 4'hF;

    always #10 clk = ~clk;

    tagged_spi_master i_tagged_spi_master (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (wr),
        .bus_rd    (rd),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq       (irq),
        .sclk      (sclk),
        .mosi      (mosi),
        .miso      (miso),
        .cs_n      (cs_n)
    );

    assign miso = slv_tx[7];

    always @(sclk) begin
        if (cs_n != 4'hF) begin
            toggles++;
            if (sclk != cpol_b) begin
                if (!cpha_b) slv_rx = {slv_rx[6:0], mosi};
                else if (slv_lead != 0) slv_tx = {slv_tx[6:0], 1'b0};
                slv_lead++;
            end else begin
                if (!cpha_b) slv_tx = {slv_tx[6:0], 1'b0};
                else slv_rx = {slv_rx[6:0], mosi};
            end
        end
    end

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // per-clock comparison against the expected select and idle clock levels
    always begin
        @(negedge clk);
        #2;
        if (!rst) begin
            if (in_byte) begin
                check("R2 select during byte", {28'h0, cs_n}, {28'h0, cur_cs});
            end else if (!pending) begin
                check("R6 select between bytes", {28'h0, cs_n}, {28'h0, held_cs});
                check("R4 idle clock level", {31'h0, sclk}, {31'h0, cpol_b});
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic set_mode(input logic en, input logic cpha, input logic cpol, input logic [7:0] n);
        pending = 1'b1;
        bus_write(4'd0, {29'h0, cpol, cpha, en});
        bus_write(4'd1, {24'h0, n});
        cpol_b = cpol;
        cpha_b = cpha;
        @(negedge clk);
        pending = 1'b0;
    endtask

    task automatic send_byte(input logic [1:0] ch, input logic eof, input logic [7:0] data,
                             input logic [7:0] resp, input int h);
        logic [31:0] v;
        int n;
        pending = 1'b1;
        slv_tx = resp; slv_rx = 8'h00; slv_lead = 0; toggles = 0;
        bus_write(4'd2, {29'h0, eof, ch});
        @(negedge clk);
        wr = 1'b1; addr = 4'd3; wdata = {24'h0, data};
        @(negedge clk);
        wr = 1'b0; rd = 1'b1; addr = 4'd6;
        #1 check("R8 tx_empty low after TXBYTE write", rdata, 32'h0);
        @(negedge clk);
        cur_cs = ~(4'b0001 << ch);
        in_byte = 1'b1;
        pending = 1'b0;
        #1;
        n = 0;
        while (rdata[0] && cycles < 150000) begin
            n++;
            @(negedge clk);
            #1;
        end
        rd = 1'b0;
        held_cs = eof ? 4'hF : ~(4'b0001 << ch);
        in_byte = 1'b0;
        check("R5 busy length", n, 17 * h);
        check("R4 sclk transitions", toggles, 16);
        check("R4 sclk back at idle", {31'h0, sclk}, {31'h0, cpol_b});
        check("R3 mosi byte MSB first", {24'h0, slv_rx}, {24'h0, data});
        check("R6 select after byte", {28'h0, cs_n}, {28'h0, held_cs});
        bus_read(4'd6, v);
        check("R8 rx_full set after byte", v, 32'h6);
        bus_read(4'd4, v);
        check("R7 echoed tag", v, {29'h0, eof, ch});
        bus_read(4'd5, v);
        check("R3 received byte", v, {24'h0, resp});
        bus_read(4'd6, v);
        check("R8 rx_full cleared by read", v, 32'h2);
    endtask

    initial begin
        logic [31:0] v;
        int n;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 selects high", {28'h0, cs_n}, 32'hF);
        check("R1 sclk low", {31'h0, sclk}, 32'h0);
        check("R1 irq low", {31'h0, irq}, 32'h0);
        bus_read(4'd6, v);
        check("R1 STATE", v, 32'h2);
        bus_read(4'd7, v);
        check("R1 EVENTS", v, 32'h0);

        set_mode(1'b1, 1'b0, 1'b0, 8'd1);
        send_byte(2'd1, 1'b0, 8'hA5, 8'h3C, 1);
        send_byte(2'd1, 1'b1, 8'h5A, 8'hC3, 1);

        set_mode(1'b1, 1'b1, 1'b1, 8'd3);
        send_byte(2'd2, 1'b1, 8'h81, 8'h7E, 3);

        set_mode(1'b1, 1'b0, 1'b1, 8'd0);
        send_byte(2'd0, 1'b0, 8'hF0, 8'h0F, 1);
        send_byte(2'd0, 1'b1, 8'hFF, 8'h96, 1);

        set_mode(1'b1, 1'b1, 1'b0, 8'd2);
        send_byte(2'd3, 1'b1, 8'h33, 8'hCC, 2);

        // R10 disabled: queued byte must wait
        set_mode(1'b0, 1'b0, 1'b0, 8'd1);
        pending = 1'b1;
        slv_tx = 8'h69; slv_rx = 8'h00; slv_lead = 0; toggles = 0;
        bus_write(4'd2, {29'h0, 1'b1, 2'd2});
        bus_write(4'd3, 32'h5C);
        repeat (20) @(negedge clk);
        check("R10 selects stay high while disabled", {28'h0, cs_n}, 32'hF);
        bus_read(4'd6, v);
        check("R10 byte held while disabled", v, 32'h0);
        bus_write(4'd0, 32'h1);
        n = 0;
        v = 32'h1;
        while ((v[2] == 1'b0) && n < 200) begin
            bus_read(4'd6, v);
            n++;
        end
        held_cs = 4'hF;
        pending = 1'b0;
        check("R10 byte done after enable", v, 32'h6);
        check("R10 mosi after enable", {24'h0, slv_rx}, 32'h5C);
        bus_read(4'd5, v);
        check("R10 received after enable", v, 32'h69);

        // R9 events and interrupt mask
        bus_read(4'd7, v);
        check("R9 both events latched", v, 32'h3);
        check("R9 mask zero keeps irq low", {31'h0, irq}, 32'h0);
        bus_write(4'd8, 32'h2);
        check("R9 rx event raises irq", {31'h0, irq}, 32'h1);
        bus_write(4'd7, 32'h2);
        check("R9 clear rx event drops irq", {31'h0, irq}, 32'h0);
        bus_read(4'd7, v);
        check("R9 one-to-clear leaves tx event", v, 32'h1);
        bus_write(4'd8, 32'h3);
        check("R9 tx event raises irq", {31'h0, irq}, 32'h1);
        bus_write(4'd7, 32'h1);
        check("R9 all cleared", {31'h0, irq}, 32'h0);
        bus_read(4'd7, v);
        check("R9 EVENTS empty", v, 32'h0);

        repeat (4) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule